// File: doc/BRIEF.md
# Serial Management Bus Master

This block is the station side of a two-wire management bus that reads and writes registers inside Ethernet PHY devices. A host pulses a start request together with a read/write select, a 5-bit PHY address, a 5-bit register address and, for writes, a 16-bit value. The block divides the system clock down to the management clock and shifts a complete 64-bit frame onto a tri-state data line. That line is presented as separate output, output-enable and input pins, so the pad itself lives outside the block.

Each management clock bit starts with a falling edge, at which the block launches the next bit. The bit then stays put through the following rising edge and the whole high phase, which gives the PHY a full half period of setup and hold. On a read, the block releases the line from the first turnaround bit to the end of the frame. It samples each returned bit in the last system cycle of the clock-low phase, which tolerates a PHY that presents data long after the rising edge. The sixteen captured bits appear on the read-data output in the same cycle as the one-cycle done pulse.

Top module: `mgmt_bus_master`

## Requirements
- R1: Out of reset and whenever busy is low, the management clock is high, the output enable is 0, the data output is 1, and done is 0.
- R2: A start request is accepted only when busy is low, and busy is high from the next cycle onward. A start request, or a change of any request input, while busy is high has no effect on the frame in progress.
- R3: Every frame is 64 bits long and begins with 32 bits of 1, followed by the start pattern 0 then 1.
- R4: Next comes the opcode, which is 1,0 for a read and 0,1 for a write. After it come the PHY address (5 bits) and then the register address (5 bits), each sent most significant bit first.
- R5: On a write, the two turnaround bits are 1 then 0, followed by the 16 write-data bits, most significant bit first. The output enable stays 1 for all 64 bits.
- R6: On a read, the output enable is 1 for bits 0 to 45 and 0 from bit 46 (the first turnaround bit) to the end of the frame, and the data output reads 1 while released. The 16 captured bits, first received bit as the most significant, appear on the read-data output with done. A write leaves the read-data output unchanged.
- R7: Each bit period is HALF_DIV system cycles with the management clock low, then HALF_DIV cycles high. A frame lasts 128*HALF_DIV cycles from the cycle after acceptance.
- R8: The data output and output enable change only together with a falling management-clock edge, or at frame start or frame end. They stay stable throughout every high phase.
- R9: Each read-data bit is taken from the data input in the last system cycle of that bit's low phase. Input values present earlier in the low phase are ignored.
- R10: Done is a one-cycle pulse, issued in the first cycle after the high phase of bit 63 ends, and busy is low in that same cycle. A start request held in the done cycle is accepted there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_start | input | 1 | Request a transaction |
| req_read | input | 1 | 1 = read, 0 = write |
| req_phy | input | 5 | Target PHY address |
| req_reg | input | 5 | Target register address |
| req_wdata | input | 16 | Write value |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 16 | Last value read |
| mgmt_clk | output | 1 | Management clock |
| mgmt_dat_o | output | 1 | Serial data driven toward the bus |
| mgmt_dat_oe | output | 1 | Drive enable for the data line |
| mgmt_dat_i | input | 1 | Serial data seen on the bus |

## Verification
The hardest situation to reach from the ports is one that separates late sampling from sampling at the clock edge. To produce it, the bench plays the PHY and, in the first system cycle of every low phase during read data, drives the inverse of the intended bit. The correct value arrives only later in that low phase, so a capture made too early collects the wrong word. Back-to-back frames are reached by holding start high through the final edge of a frame: that edge must ignore it, and the done cycle must accept it. Request inputs are also toggled in the middle of a read to show they are latched.

// File: rtl/mgmt_bus_pkg.sv
package mgmt_bus_pkg;
   localparam int ADDR_W     = 5;
   localparam int DATA_W     = 16;
   localparam int PRE_BITS   = 32;
   localparam int FRAME_BITS = PRE_BITS + 4 + 2*ADDR_W + 2 + DATA_W;
   localparam int TA_POS     = PRE_BITS + 4 + 2*ADDR_W;
   localparam int DATA_POS   = TA_POS + 2;

   localparam logic [1:0] SOF_PAT = 2'b01;
   localparam logic [1:0] OP_RD   = 2'b10;
   localparam logic [1:0] OP_WR   = 2'b01;
   localparam logic [1:0] TA_WR   = 2'b10;
   localparam logic [1:0] TA_RD   = 2'b11;

   typedef enum logic {PH_LOW, PH_HIGH} phase_e;

   function automatic logic [FRAME_BITS-1:0] build_frame(
      input logic              rd,
      input logic [ADDR_W-1:0] phy,
      input logic [ADDR_W-1:0] reg_a,
      input logic [DATA_W-1:0] wd);
      build_frame = {{PRE_BITS{1'b1}}, SOF_PAT, (rd ? OP_RD : OP_WR), phy, reg_a,
                     (rd ? TA_RD : TA_WR), (rd ? {DATA_W{1'b1}} : wd)};
   endfunction
endpackage

// File: rtl/mgmt_half_timer.sv
module mgmt_half_timer #(
   parameter int HALF_DIV = 50
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart,
   input  logic run,
   output logic half_end
);
   localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
   localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

   logic [CW-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n)                  cnt <= '0;
      else if (restart || !run)    cnt <= '0;
      else if (cnt == LAST)        cnt <= '0;
      else                         cnt <= cnt + 1'b1;
   end

   assign half_end = run && (cnt == LAST);
endmodule

// File: rtl/mgmt_frame_seq.sv
module mgmt_frame_seq
   import mgmt_bus_pkg::*;
(
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  start_acc,
   input  logic                  rd_in,
   input  logic [FRAME_BITS-1:0] frame_in,
   input  logic                  half_end,
   output logic                  busy,
   output logic                  done,
   output logic                  rd_mode,
   output logic                  sample_now,
   output logic                  frame_end,
   output logic                  mclk,
   output logic                  dout,
   output logic                  doe
);
   localparam int BW = $clog2(FRAME_BITS);
   localparam logic [BW-1:0] LAST_BIT = BW'(FRAME_BITS - 1);
   localparam logic [BW-1:0] TA_IDX   = BW'(TA_POS);
   localparam logic [BW-1:0] DAT_IDX  = BW'(DATA_POS);

   phase_e                phase;
   logic [BW-1:0]         bit_cnt;
   logic [BW-1:0]         nxt_bit;
   logic [FRAME_BITS-1:0] shreg;

   assign nxt_bit    = bit_cnt + 1'b1;
   assign frame_end  = busy && half_end && (phase == PH_HIGH) && (bit_cnt == LAST_BIT);
   assign sample_now = busy && half_end && (phase == PH_LOW) && rd_mode && (bit_cnt >= DAT_IDX);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy    <= 1'b0;
         done    <= 1'b0;
         rd_mode <= 1'b0;
         phase   <= PH_LOW;
         bit_cnt <= '0;
         shreg   <= '0;
         mclk    <= 1'b1;
         dout    <= 1'b1;
         doe     <= 1'b0;
      end else begin
         done <= 1'b0;
         if (start_acc) begin
            busy    <= 1'b1;
            rd_mode <= rd_in;
            phase   <= PH_LOW;
            bit_cnt <= '0;
            shreg   <= frame_in;
            mclk    <= 1'b0;
            dout    <= frame_in[FRAME_BITS-1];
            doe     <= 1'b1;
         end else if (busy && half_end) begin
            if (phase == PH_LOW) begin
               phase <= PH_HIGH;
               mclk  <= 1'b1;
            end else if (frame_end) begin
               busy  <= 1'b0;
               done  <= 1'b1;
               phase <= PH_LOW;
               dout  <= 1'b1;
               doe   <= 1'b0;
            end else begin
               phase   <= PH_LOW;
               bit_cnt <= nxt_bit;
               shreg   <= {shreg[FRAME_BITS-2:0], 1'b0};
               mclk    <= 1'b0;
               dout    <= shreg[FRAME_BITS-2];
               doe     <= !(rd_mode && (nxt_bit >= TA_IDX));
            end
         end
      end
   end
endmodule

// File: rtl/mgmt_rd_capture.sv
module mgmt_rd_capture #(
   parameter int DW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          sample_now,
   input  logic          din,
   input  logic          frame_end,
   input  logic          rd_mode,
   output logic [DW-1:0] rd_data
);
   logic [DW-1:0] shift;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         shift   <= '0;
         rd_data <= '0;
      end else begin
         if (sample_now)
            shift <= {shift[DW-2:0], din};
         if (frame_end && rd_mode)
            rd_data <= shift;
      end
   end
endmodule

// File: rtl/mgmt_bus_master.sv
module mgmt_bus_master
   import mgmt_bus_pkg::*;
#(
   parameter int HALF_DIV = 50
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_start,
   input  logic              req_read,
   input  logic [ADDR_W-1:0] req_phy,
   input  logic [ADDR_W-1:0] req_reg,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              busy,
   output logic              done,
   output logic [DATA_W-1:0] rd_data,
   output logic              mgmt_clk,
   output logic              mgmt_dat_o,
   output logic              mgmt_dat_oe,
   input  logic              mgmt_dat_i
);
   if (HALF_DIV < 2) begin : g_bad_div
      $error("HALF_DIV must be at least 2 so read sampling sits late in the low phase");
   end
   if (FRAME_BITS != 64) begin : g_bad_frame
      $error("frame layout must total 64 bits");
   end

   logic start_acc, half_end, rd_mode, sample_now, frame_end;
   logic [FRAME_BITS-1:0] frame;

   assign start_acc = req_start && !busy;
   assign frame     = build_frame(req_read, req_phy, req_reg, req_wdata);

   mgmt_half_timer #(.HALF_DIV(HALF_DIV)) u_timer (
      .clk(clk), .rst_n(rst_n), .restart(start_acc), .run(busy), .half_end(half_end));

   mgmt_frame_seq u_seq (
      .clk(clk), .rst_n(rst_n), .start_acc(start_acc), .rd_in(req_read),
      .frame_in(frame), .half_end(half_end), .busy(busy), .done(done),
      .rd_mode(rd_mode), .sample_now(sample_now), .frame_end(frame_end),
      .mclk(mgmt_clk), .dout(mgmt_dat_o), .doe(mgmt_dat_oe));

   mgmt_rd_capture #(.DW(DATA_W)) u_cap (
      .clk(clk), .rst_n(rst_n), .sample_now(sample_now), .din(mgmt_dat_i),
      .frame_end(frame_end), .rd_mode(rd_mode), .rd_data(rd_data));
endmodule

// File: rtl/mgmt_bus_master_chk.sv
module mgmt_bus_master_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        req_start,
   input logic        busy,
   input logic        done,
   input logic [15:0] rd_data,
   input logic        mgmt_clk,
   input logic        mgmt_dat_o,
   input logic        mgmt_dat_oe
);
   p_idle_released_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (mgmt_clk && !mgmt_dat_oe && mgmt_dat_o));

   p_busy_needs_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(req_start));

   p_start_launch_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (req_start && !busy) |=> (busy && !mgmt_clk && mgmt_dat_oe));

   p_stable_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && mgmt_clk) |-> ($stable(mgmt_dat_o) && $stable(mgmt_dat_oe)));

   p_release_on_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(mgmt_dat_oe) && busy) |-> !mgmt_clk);

   p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   p_done_ends_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy && $past(busy)));

   p_rdata_at_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(rd_data) |-> done);
endmodule

bind mgmt_bus_master mgmt_bus_master_chk u_chk (
   .clk(clk), .rst_n(rst_n), .req_start(req_start), .busy(busy), .done(done),
   .rd_data(rd_data), .mgmt_clk(mgmt_clk), .mgmt_dat_o(mgmt_dat_o),
   .mgmt_dat_oe(mgmt_dat_oe));

// File: tb/mgmt_bus_master_tb.sv
module mgmt_bus_master_tb;
   localparam int H   = 3;
   localparam int FRM = 128 * H;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_start = 1'b0, req_read = 1'b0;
   logic [4:0]  req_phy = '0, req_reg = '0;
   logic [15:0] req_wdata = '0;
   logic        busy, done, mgmt_clk, mgmt_dat_o, mgmt_dat_oe;
   logic        mgmt_dat_i = 1'b1;
   logic [15:0] rd_data;

   int vectors = 0, misses = 0;

   mgmt_bus_master #(.HALF_DIV(H)) u_dut (
      .clk(clk), .rst_n(rst_n), .req_start(req_start), .req_read(req_read),
      .req_phy(req_phy), .req_reg(req_reg), .req_wdata(req_wdata),
      .busy(busy), .done(done), .rd_data(rd_data), .mgmt_clk(mgmt_clk),
      .mgmt_dat_o(mgmt_dat_o), .mgmt_dat_oe(mgmt_dat_oe), .mgmt_dat_i(mgmt_dat_i));

   always #2 clk = ~clk;

   // behavioural reference: mt = cycles since acceptance, -1 when idle
   int          mt = -1;
   logic        mrd = 1'b0, m_acc = 1'b0;
   logic [63:0] mframe = '1;
   logic [15:0] mcap = '0, e_rdata = '0, phy_word = '0;
   logic        e_done = 1'b0, e_busy = 1'b0;

   function automatic logic [63:0] mk_frame(logic rd, logic [4:0] p, logic [4:0] r, logic [15:0] w);
      logic [63:0] f;
      f = '1;
      f[31:30] = 2'b01;
      f[29:28] = rd ? 2'b10 : 2'b01;
      f[27:23] = p;
      f[22:18] = r;
      f[17:16] = rd ? 2'b11 : 2'b10;
      f[15:0]  = rd ? 16'hFFFF : w;
      return f;
   endfunction

   always @(posedge clk) begin
      m_acc = 1'b0;
      e_done = 1'b0;
      if (!rst_n) begin
         mt = -1; e_busy = 1'b0; e_rdata = '0;
      end else if (mt >= 0) begin
         mt++;
         if (mt % (2*H) == H && mrd && mt / (2*H) >= 48)
            mcap = {mcap[14:0], mgmt_dat_i};
         if (mt == FRM) begin
            e_done = 1'b1; e_busy = 1'b0; mt = -1;
            if (mrd) e_rdata = mcap;
         end
      end else if (req_start) begin
         mt = 0; m_acc = 1'b1; e_busy = 1'b1; mrd = req_read;
         mframe = mk_frame(req_read, req_phy, req_reg, req_wdata);
      end
   end

   function automatic string tag_out(int t);
      int b;
      b = t / (2*H);
      if (t % (2*H) >= H) return "R8";
      if (b < 34) return "R3";
      if (b < 46) return "R4";
      return mrd ? "R6" : "R5";
   endfunction

   // compare every cycle and play the PHY on the data input
   always @(negedge clk) begin
      logic e_clk, e_out, e_oe;
      int b;
      if (mt < 0) begin
         e_clk = 1'b1; e_out = 1'b1; e_oe = 1'b0; b = 0;
      end else begin
         b = mt / (2*H);
         e_clk = (mt % (2*H)) >= H;
         e_out = mframe[63-b];
         e_oe  = !(mrd && b >= 46);
      end
      vectors++;
      if (mgmt_clk !== e_clk) begin
         misses++; $display("FAIL %s mgmt_clk t=%0d got %b exp %b", (mt < 0) ? "R1" : "R7", mt, mgmt_clk, e_clk);
      end
      if (mgmt_dat_o !== e_out) begin
         misses++; $display("FAIL %s mgmt_dat_o t=%0d got %b exp %b", (mt < 0) ? "R1" : tag_out(mt), mt, mgmt_dat_o, e_out);
      end
      if (mgmt_dat_oe !== e_oe) begin
         misses++; $display("FAIL %s mgmt_dat_oe t=%0d got %b exp %b", (mt < 0) ? "R1" : (mrd ? "R6" : "R5"), mt, mgmt_dat_oe, e_oe);
      end
      if (busy !== e_busy) begin
         misses++; $display("FAIL R2 busy t=%0d got %b exp %b", mt, busy, e_busy);
      end
      if (done !== e_done) begin
         misses++; $display("FAIL R10 done t=%0d got %b exp %b", mt, done, e_done);
      end
      if (rd_data !== e_rdata) begin
         misses++; $display("FAIL R6 R9 rd_data got %h exp %h", rd_data, e_rdata);
      end
      if (mt >= 0 && mrd && b >= 48)
         mgmt_dat_i <= (mt % (2*H) == 0) ? ~phy_word[15-(b-48)] : phy_word[15-(b-48)];
      else
         mgmt_dat_i <= 1'b1;
   end

   task automatic issue(logic rd, logic [4:0] p, logic [4:0] r, logic [15:0] w);
      @(negedge clk);
      req_start = 1'b1; req_read = rd; req_phy = p; req_reg = r; req_wdata = w;
      do @(negedge clk); while (!m_acc);
      req_start = 1'b0;
   endtask

   task automatic wait_idle();
      do @(negedge clk); while (mt >= 0);
   endtask

   task automatic wait_near_end();
      do @(negedge clk); while (mt != FRM - 2);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      misses++;
      $display("FAIL R2 watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);                         // R1 idle state
      issue(1'b0, 5'h1A, 5'h05, 16'hA5C3);               // R3 R4 R5 R7 R8 write
      wait_idle();
      phy_word = 16'h8E71;
      issue(1'b1, 5'h03, 5'h1F, 16'h0000);               // R6 R9 read
      repeat (40 * H) @(negedge clk);
      req_start = 1'b1; req_read = 1'b0; req_phy = 5'h11; req_reg = 5'h0A;   // R2 ignored while busy
      req_wdata = 16'h1234;
      repeat (3) @(negedge clk);
      req_start = 1'b0;
      repeat (60 * H) @(negedge clk);
      req_read = 1'b1; req_phy = 5'h00;                  // R2 mid-frame input change
      wait_near_end();
      phy_word = 16'h0001;
      issue(1'b1, 5'h1F, 5'h00, 16'hFFFF);               // R10 back-to-back start held in done cycle
      wait_idle();
      issue(1'b0, 5'h00, 5'h00, 16'h0000);               // R5 all-zero write, R6 rd_data kept
      wait_idle();
      issue(1'b0, 5'h1F, 5'h1F, 16'hFFFF);               // R4 R5 all-ones fields
      wait_idle();
      phy_word = 16'h7FFE;
      issue(1'b1, 5'h15, 5'h0A, 16'h5555);               // R9 alternating-edge read data
      wait_idle();
      repeat (6) @(negedge clk);                         // R1 idle after frames
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
   end
endmodule